// File: doc/BRIEF.md
# Nested Priority Event Controller

This block sits beside a processor core and decides when the core is diverted to an event handler. It has sixteen event levels, numbered 0 to 15, and a lower number means higher priority. A request for a level is caught in a latch register and stays there until that level is taken. A per-level enable mask decides which latched levels may be taken at all. A pending register records the levels whose handlers are running. Bits of interrupted, lower-priority handlers stay set while a higher-priority handler runs on top of them.

Level 4 is not a real event. Its pending bit works as a global hold. It sets every time a level is taken, and no further level can be taken until the running handler reports that its return state is saved. A return strobe retires the running handler. Software changes the mask in one of two ways: a save-and-clear followed by a restore (with extra bits ORed in), or a direct write. Each accepted activation appears as a one-cycle pulse that carries the level number.

Top module: `nest_evt_ctrl`

## Requirements
- R1: After synchronous reset the latch, pending and mask registers read all zeros and `act_vld_o` is low.
- R2: A `raise_i[k]` pulse (k not 4) sets latch bit k at the next clock edge whether or not mask bit k is set. The bit stays set until level k is taken.
- R3: A level whose mask bit is clear is never taken, however long it stays latched.
- R4: When a level is taken, `act_vld_o` is high for exactly one cycle and `act_lvl_o` gives the level. In that same cycle the level's pending bit and pending bit 4 read as set, and its latch bit reads as clear.
- R5: While pending bit 4 is set, no level is taken, even when a latched and unmasked level is waiting.
- R6: A `nest_en_i` pulse clears pending bit 4. A level that was waiting is then taken at the second clock edge after the pulse.
- R7: Among latched, unmasked levels the lowest number wins. It is taken only if its number is below every set pending bit other than bit 4.
- R8: An `rti_i` pulse clears the lowest-numbered set pending bit other than bit 4, and it also clears bit 4. A lower-priority latched level may then be taken.
- R9: The mask has three operations. `msk_clr_i` copies the mask into a save register and clears the mask. `msk_rest_i` loads the mask with the saved value ORed with `msk_rest_bits_i`. `msk_wr_i` loads `msk_wdata_i`. When more than one is asserted, the write wins over the restore, and the restore wins over the clear.
- R10: When a raise for level k arrives in the same cycle that level k is taken, latch bit k stays set.
- R11: Level 4 is reserved. `raise_i[4]` is ignored, and latch bit 4 and mask bit 4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raise_i | input | 16 | Per-level request strobes |
| msk_clr_i | input | 1 | Save mask, then clear it |
| msk_rest_i | input | 1 | Restore saved mask ORed with extra bits |
| msk_rest_bits_i | input | 16 | Bits ORed in on restore |
| msk_wr_i | input | 1 | Direct mask write strobe |
| msk_wdata_i | input | 16 | Direct mask write value |
| nest_en_i | input | 1 | Handler has saved its return state; clears the global hold |
| rti_i | input | 1 | Handler return; retires the highest-priority pending level |
| act_vld_o | output | 1 | One-cycle activation pulse |
| act_lvl_o | output | 4 | Level being activated |
| lat_o | output | 16 | Latch register |
| pend_o | output | 16 | Pending register (bit 4 = global hold) |
| mask_o | output | 16 | Mask register |

## Verification
Several requests are raised while all of them are masked. Levels are then unmasked one step at a time, in an order that is not their priority order, so a level being taken can be told apart from the lowest-numbered latched level simply winning. Some unmasking is done while the global hold is set and some after it is released, which separates the mask gate from the hold gate. The mask is changed both by the save/restore pair and by the direct write, and the write is also combined with a clear in one cycle, which shows the precedence. Finally, return strobes peel pending levels off one at a time so that a lower-priority waiter becomes eligible. A raise lands exactly on the activation cycle of its own level, and the reserved level is poked directly.

// File: rtl/nec_pkg.sv
package nec_pkg;
  typedef enum logic [1:0] {
    MOP_NONE = 2'd0,
    MOP_CLR  = 2'd1,
    MOP_REST = 2'd2,
    MOP_WR   = 2'd3
  } mask_op_e;
endpackage

// File: rtl/nec_prio_enc.sv
// Lowest-index-wins priority encoder.
module nec_prio_enc #(
  parameter int W  = 16,
  localparam int LW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req,
  output logic          hit,
  output logic [LW-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = LW'(i);
      end
    end
  end
endmodule

// File: rtl/nec_mask.sv
// Mask register with save/clear, restore-with-OR and direct write.
module nec_mask
  import nec_pkg::*;
#(
  parameter int N    = 16,
  parameter int GDIS = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  mask_op_e     op,
  input  logic [N-1:0] rest_bits,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] mask_q
);
  localparam logic [N-1:0] RSV_BIT = {{(N-1){1'b0}}, 1'b1} << GDIS;

  logic [N-1:0] save_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      save_q <= '0;
    end else begin
      case (op)
        MOP_WR:   mask_q <= wdata & ~RSV_BIT;
        MOP_REST: mask_q <= (save_q | rest_bits) & ~RSV_BIT;
        MOP_CLR: begin
          save_q <= mask_q;
          mask_q <= '0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nec_latch.sv
// Request latch: set by raise, cleared by activation; raise wins.
module nec_latch #(
  parameter int N    = 16,
  parameter int GDIS = 4,
  localparam int LW  = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  raise,
  input  logic          take_vld,
  input  logic [LW-1:0] take_idx,
  output logic [N-1:0]  lat_q
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    if (k == GDIS) begin : g_rsv
      assign lat_q[k] = 1'b0;
    end else begin : g_lvl
      logic bit_q;
      always_ff @(posedge clk) begin
        if (rst)
          bit_q <= 1'b0;
        else if (raise[k])
          bit_q <= 1'b1;
        else if (take_vld && (take_idx == LW'(k)))
          bit_q <= 1'b0;
      end
      assign lat_q[k] = bit_q;
    end
  end
endmodule

// File: rtl/nec_pend.sv
// Pending register with global-hold bit and return handling.
module nec_pend #(
  parameter int N    = 16,
  parameter int GDIS = 4,
  localparam int LW  = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take_vld,
  input  logic [LW-1:0] take_idx,
  input  logic          rti,
  input  logic          nest_en,
  output logic [N-1:0]  pend_q,
  output logic          top_hit,
  output logic [LW-1:0] top_idx
);
  localparam logic [N-1:0] RSV_BIT = {{(N-1){1'b0}}, 1'b1} << GDIS;

  logic [N-1:0] pend_nxt;

  nec_prio_enc #(.W(N)) u_top (
    .req (pend_q & ~RSV_BIT),
    .hit (top_hit),
    .idx (top_idx)
  );

  always_comb begin
    pend_nxt = pend_q;
    if (rti && top_hit) pend_nxt[top_idx] = 1'b0;
    if (rti || nest_en) pend_nxt[GDIS] = 1'b0;
    if (take_vld) begin
      pend_nxt[take_idx] = 1'b1;
      pend_nxt[GDIS]     = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_nxt;
  end
endmodule

// File: rtl/nest_evt_ctrl.sv
module nest_evt_ctrl
  import nec_pkg::*;
#(
  parameter int N_LVL = 16,
  parameter int GDIS  = 4,
  localparam int LW   = $clog2(N_LVL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_LVL-1:0] raise_i,
  input  logic             msk_clr_i,
  input  logic             msk_rest_i,
  input  logic [N_LVL-1:0] msk_rest_bits_i,
  input  logic             msk_wr_i,
  input  logic [N_LVL-1:0] msk_wdata_i,
  input  logic             nest_en_i,
  input  logic             rti_i,
  output logic             act_vld_o,
  output logic [LW-1:0]    act_lvl_o,
  output logic [N_LVL-1:0] lat_o,
  output logic [N_LVL-1:0] pend_o,
  output logic [N_LVL-1:0] mask_o
);
  mask_op_e         mop;
  logic [N_LVL-1:0] cand;
  logic             cand_hit;
  logic [LW-1:0]    cand_idx;
  logic             top_hit;
  logic [LW-1:0]    top_idx;
  logic             take;

  always_comb begin
    if (msk_wr_i)        mop = MOP_WR;
    else if (msk_rest_i) mop = MOP_REST;
    else if (msk_clr_i)  mop = MOP_CLR;
    else                 mop = MOP_NONE;
  end

  nec_mask #(.N(N_LVL), .GDIS(GDIS)) u_mask (
    .clk       (clk),
    .rst       (rst),
    .op        (mop),
    .rest_bits (msk_rest_bits_i),
    .wdata     (msk_wdata_i),
    .mask_q    (mask_o)
  );

  nec_latch #(.N(N_LVL), .GDIS(GDIS)) u_latch (
    .clk      (clk),
    .rst      (rst),
    .raise    (raise_i),
    .take_vld (take),
    .take_idx (cand_idx),
    .lat_q    (lat_o)
  );

  nec_pend #(.N(N_LVL), .GDIS(GDIS)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .take_vld (take),
    .take_idx (cand_idx),
    .rti      (rti_i),
    .nest_en  (nest_en_i),
    .pend_q   (pend_o),
    .top_hit  (top_hit),
    .top_idx  (top_idx)
  );

  assign cand = lat_o & mask_o;

  nec_prio_enc #(.W(N_LVL)) u_cand (
    .req (cand),
    .hit (cand_hit),
    .idx (cand_idx)
  );

  assign take = cand_hit && !pend_o[GDIS] && (!top_hit || (cand_idx < top_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      act_vld_o <= 1'b0;
      act_lvl_o <= '0;
    end else begin
      act_vld_o <= take;
      if (take) act_lvl_o <= cand_idx;
    end
  end
endmodule

// File: rtl/nec_chk.sv
module nec_chk #(
  parameter int N_LVL = 16,
  parameter int GDIS  = 4,
  localparam int LW   = $clog2(N_LVL)
) (
  input logic             clk,
  input logic             rst,
  input logic [N_LVL-1:0] raise_i,
  input logic             act_vld_o,
  input logic [LW-1:0]    act_lvl_o,
  input logic [N_LVL-1:0] lat_o,
  input logic [N_LVL-1:0] pend_o,
  input logic [N_LVL-1:0] mask_o
);
  logic [N_LVL-1:0] prv_mask;
  logic [N_LVL-1:0] prv_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      prv_mask <= '0;
      prv_pend <= '0;
    end else begin
      prv_mask <= mask_o;
      prv_pend <= pend_o;
    end
  end

  p_masked_never_r3: assert property (@(posedge clk) disable iff (rst)
    act_vld_o |-> prv_mask[act_lvl_o]);

  p_hold_blocks_r5: assert property (@(posedge clk) disable iff (rst)
    act_vld_o |-> !prv_pend[GDIS]);

  p_take_marks_r4: assert property (@(posedge clk) disable iff (rst)
    act_vld_o |-> (pend_o[act_lvl_o] && pend_o[GDIS]));

  p_one_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    act_vld_o |=> !act_vld_o);

  p_reserved_r11: assert property (@(posedge clk) disable iff (rst)
    !lat_o[GDIS] && !mask_o[GDIS]);

  for (genvar k = 0; k < N_LVL; k++) begin : g_raise
    if (k != GDIS) begin : g_chk
      p_raise_latch_r2: assert property (@(posedge clk) disable iff (rst)
        raise_i[k] |=> lat_o[k]);
    end
  end
endmodule

bind nest_evt_ctrl nec_chk #(.N_LVL(N_LVL), .GDIS(GDIS)) u_nec_chk (
  .clk       (clk),
  .rst       (rst),
  .raise_i   (raise_i),
  .act_vld_o (act_vld_o),
  .act_lvl_o (act_lvl_o),
  .lat_o     (lat_o),
  .pend_o    (pend_o),
  .mask_o    (mask_o)
);

// File: tb/test_nest_evt_ctrl.sv
module test_nest_evt_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] raise_i = '0;
  logic        msk_clr_i = 1'b0, msk_rest_i = 1'b0, msk_wr_i = 1'b0;
  logic [15:0] msk_rest_bits_i = '0, msk_wdata_i = '0;
  logic        nest_en_i = 1'b0, rti_i = 1'b0;
  logic        act_vld_o;
  logic [3:0]  act_lvl_o;
  logic [15:0] lat_o, pend_o, mask_o;

  int vecs = 0, fails = 0, cycles = 0;

  always #10 clk = ~clk;

  nest_evt_ctrl i_nest_evt_ctrl (
    .clk(clk), .rst(rst), .raise_i(raise_i),
    .msk_clr_i(msk_clr_i), .msk_rest_i(msk_rest_i), .msk_rest_bits_i(msk_rest_bits_i),
    .msk_wr_i(msk_wr_i), .msk_wdata_i(msk_wdata_i),
    .nest_en_i(nest_en_i), .rti_i(rti_i),
    .act_vld_o(act_vld_o), .act_lvl_o(act_lvl_o),
    .lat_o(lat_o), .pend_o(pend_o), .mask_o(mask_o)
  );

  // Behavioural reference model
  bit [15:0] m_lat, m_pend, m_mask, m_save;
  bit        m_vld;
  int        m_lvl;

  always @(posedge clk) begin
    int win, top;
    bit ok;
    bit [15:0] nl, np, nm;
    if (rst) begin
      m_lat = 0; m_pend = 0; m_mask = 0; m_save = 0; m_vld = 0; m_lvl = 0;
    end else begin
      win = -1;
      for (int i = 15; i >= 0; i--) if (m_lat[i] && m_mask[i]) win = i;
      top = 16;
      for (int i = 15; i >= 0; i--) if (i != 4 && m_pend[i]) top = i;
      ok = (win >= 0) && !m_pend[4] && (win < top);
      nl = m_lat;
      if (ok) nl[win] = 0;
      nl = nl | (raise_i & 16'hFFEF);
      np = m_pend;
      if (rti_i && top < 16) np[top] = 0;
      if (rti_i || nest_en_i) np[4] = 0;
      if (ok) begin np[win] = 1; np[4] = 1; end
      nm = m_mask;
      if (msk_wr_i) nm = msk_wdata_i & 16'hFFEF;
      else if (msk_rest_i) nm = (m_save | msk_rest_bits_i) & 16'hFFEF;
      else if (msk_clr_i) begin m_save = m_mask; nm = 0; end
      m_lat = nl; m_pend = np; m_mask = nm;
      m_vld = ok;
      if (ok) m_lvl = win;
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      vecs++;
      if (lat_o !== m_lat) begin fails++; $display("FAIL R2 latch act=%h exp=%h", lat_o, m_lat); end
      if (pend_o !== m_pend) begin fails++; $display("FAIL R4 pending act=%h exp=%h", pend_o, m_pend); end
      if (mask_o !== m_mask) begin fails++; $display("FAIL R9 mask act=%h exp=%h", mask_o, m_mask); end
      if (act_vld_o !== m_vld) begin fails++; $display("FAIL R7 act_vld act=%0b exp=%0b", act_vld_o, m_vld); end
      else if (m_vld && act_lvl_o != m_lvl[3:0]) begin
        fails++; $display("FAIL R7 act_lvl act=%0d exp=%0d", act_lvl_o, m_lvl);
      end
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    vecs++;
    if (!ok) begin fails++; $display("FAIL %s act=%h exp=%h", tag, act, exp); end
  endtask

  task automatic cyc();
    @(negedge clk);
    raise_i = '0; msk_clr_i = 0; msk_rest_i = 0; msk_wr_i = 0;
    nest_en_i = 0; rti_i = 0;
  endtask

  task automatic wait_act(int lvl, int maxc, string tag);
    int got = -1;
    for (int c = 0; c < maxc; c++) begin
      cyc();
      if (act_vld_o) begin got = act_lvl_o; break; end
    end
    check(got == lvl, tag, got, lvl);
  endtask

  task automatic quiet(int n, string tag);
    int seen = 0;
    for (int c = 0; c < n; c++) begin
      cyc();
      if (act_vld_o) seen++;
    end
    check(seen == 0, tag, seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(lat_o == 0 && pend_o == 0 && mask_o == 0 && !act_vld_o, "R1 reset", {lat_o, pend_o}, 0);

    msk_wr_i = 1; msk_wdata_i = 16'h8000; raise_i = 16'h8000;
    wait_act(15, 5, "R7 first take");
    check(pend_o == 16'h8010 && lat_o == 0, "R4 pend after take", pend_o, 16'h8010);
    nest_en_i = 1; cyc();
    check(pend_o == 16'h8000, "R6 hold cleared", pend_o, 16'h8000);

    raise_i = 16'h1260; cyc();
    check(lat_o == 16'h1260, "R2 masked raises latched", lat_o, 16'h1260);
    quiet(30, "R3 masked never taken");

    msk_clr_i = 1; cyc();
    check(mask_o == 0, "R9 save-and-clear", mask_o, 0);
    msk_rest_i = 1; msk_rest_bits_i = 16'h1000;
    wait_act(12, 5, "R7 lowest unmasked wins");
    check(mask_o == 16'h9000, "R9 restore with OR", mask_o, 16'h9000);

    raise_i = 16'h0800; cyc();
    msk_clr_i = 1; cyc();
    msk_rest_i = 1; msk_rest_bits_i = 16'h0200; cyc();
    quiet(10, "R5 hold blocks level 9");
    nest_en_i = 1;
    wait_act(9, 2, "R6 take after nest enable");

    msk_clr_i = 1; cyc();
    msk_rest_i = 1; msk_rest_bits_i = 16'h0040; cyc();
    quiet(10, "R5 hold blocks level 6");
    nest_en_i = 1;
    wait_act(6, 2, "R6 take after nest enable");

    nest_en_i = 1; cyc();
    msk_wr_i = 1; msk_wdata_i = 16'h9260;
    wait_act(5, 4, "R9 direct write unmasks");
    check(pend_o == 16'h9270, "R4 nested pending", pend_o, 16'h9270);
    check(lat_o == 16'h0800, "R2 level 11 still latched", lat_o, 16'h0800);

    nest_en_i = 1; cyc();
    msk_wr_i = 1; msk_wdata_i = 16'h9A60; cyc();
    quiet(5, "R7 lower priority than pending");
    rti_i = 1; cyc();
    check(pend_o == 16'h9240, "R8 return retires 5 and hold", pend_o, 16'h9240);
    quiet(3, "R7 still below pending 6");
    rti_i = 1; cyc();
    rti_i = 1;
    wait_act(11, 4, "R8 waiter taken after returns");
    check(pend_o == 16'h9810, "R8 pending after take", pend_o, 16'h9810);

    nest_en_i = 1; cyc();
    raise_i = 16'h0008; msk_wr_i = 1; msk_wdata_i = 16'h9A68; cyc();
    raise_i = 16'h0008; cyc();
    check(act_vld_o && act_lvl_o == 3, "R4 take level 3", act_lvl_o, 3);
    check(lat_o[3] == 1'b1, "R10 raise on take keeps latch", lat_o, 16'h0008);

    raise_i = 16'h0010; msk_wr_i = 1; msk_wdata_i = 16'hFFFF; cyc();
    check(lat_o[4] == 1'b0 && mask_o == 16'hFFEF, "R11 reserved level", mask_o, 16'hFFEF);

    msk_clr_i = 1; msk_wr_i = 1; msk_wdata_i = 16'h0001; cyc();
    check(mask_o == 16'h0001, "R9 write beats clear", mask_o, 16'h0001);

    repeat (4) cyc();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog (all requirements) act=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end
endmodule